// File: doc/BRIEF.md
# Dual-Stream Instruction Prefetcher with Branch Steering

This block fetches code for an instruction decoder. It holds two line buffers of `LINE_BYTES` bytes each. Only one buffer is the fetch target at any moment. That buffer asks the code cache for whole lines at rising line addresses, and each line arrives in one beat over a `LINE_BYTES*8`-bit response path. The cache marks each returned line with an optional branch offset. The block forms the byte address of that branch and looks it up in a small direct-mapped branch target table. On a miss, sequential fetching goes on into the same buffer. On a hit, the fetch target moves to the other buffer, and that buffer loads from the stored target address.

Bytes are handed to the decoder one per beat through a valid/ready pair, in program order. This order runs across the predicted jump: the buffer that ends in the taken branch drains up to and including the branch byte, and then the stream continues from the target byte in the other buffer.

The branch table is written through an update port. A flush input empties both buffers. It drops any line that is still in flight and restarts sequential fetching in buffer 0 at the redirect address.

Top module: `pf_dual_fetch`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `out_valid` is 0. The first line request after reset is for the line that holds `RESET_PC`, and delivery starts at the byte `RESET_PC`.
- R2: When no taken branch is predicted, the line requests go up by `LINE_BYTES`. The bytes come out with `out_pc` rising by one each beat. Each byte is the one at `out_pc`, where byte i of `rsp_data` (bits 8i+7..8i) is the byte at line address + i.
- R3: `req_addr` is always line aligned. A buffer is loaded from a single `rsp_valid` beat, and delivery from that line begins at the fetch byte offset within it.
- R4: At most one line request is outstanding. A request held without `req_ready` keeps its address. A buffer receives no new line until the decoder has taken every byte of its previous line, so with `out_ready` low and no taken branch, exactly one line is fetched.
- R5: When a line is flagged with a branch (`rsp_br_valid`, offset `rsp_br_off`) whose address misses in the table, the whole line is delivered and fetching continues sequentially.
- R6: When the flagged branch address hits, delivery stops after the branch byte and goes on at the stored target byte. The target line is fetched into the other buffer while the first buffer still holds undelivered bytes, and later lines go on sequentially from the target.
- R7: A branch offset below the offset where delivery in that line starts is ignored, and the line is handled as if it had no branch.
- R8: The table is direct-mapped, indexed by the low `log2(BTB_DEPTH)` bits of the branch byte address and tagged with the rest. An update writes the entry at its index and replaces whatever was there. An update with `upd_valid` = 0 makes that branch miss.
- R9: A flush makes `out_valid` 0 in the next cycle. Delivery then resumes at `flush_addr`, and no byte of a line requested before the flush is delivered.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_byte` and `out_pc` stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard buffered and in-flight code, redirect fetch |
| flush_addr | input | ADDR_W | Byte address to restart from after a flush |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Cache accepts the line request |
| req_addr | output | ADDR_W | Line-aligned request address |
| rsp_valid | input | 1 | Requested line is present on rsp_data |
| rsp_data | input | LINE_BYTES*8 | Whole code line, byte i at bits 8i+7..8i |
| rsp_br_valid | input | 1 | The line holds a branch |
| rsp_br_off | input | log2(LINE_BYTES) | Byte offset of the branch within the line |
| upd_en | input | 1 | Write one branch table entry |
| upd_pc | input | ADDR_W | Branch byte address for the update |
| upd_tgt | input | ADDR_W | Predicted target byte address |
| upd_valid | input | 1 | Entry valid flag written by the update |
| out_valid | output | 1 | A code byte is offered to the decoder |
| out_ready | input | 1 | Decoder takes the byte |
| out_byte | output | 8 | Code byte |
| out_pc | output | ADDR_W | Byte address of out_byte |

## Verification
The bench builds the block with its default sizes: 32-bit addresses, 32-byte lines and a 16-entry table. `RESET_PC` is raised to an offset inside a line, so the very first line already exercises a mid-line start. With 16 entries, two branch addresses that share their low four bits, 0x40A and 0x61A, collide in one slot. The replacement and invalidation cases can therefore be reached with a few updates. A cache model with a two-cycle return lets a flush land while a request is accepted or in flight, and holding the decoder's ready low shows both buffers filling across a predicted jump.

// File: rtl/pf_pkg.sv
package pf_pkg;

  // Line fetch sequencer states
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } pf_fetch_state_e;

endpackage

// File: rtl/pf_btb.sv
// Direct-mapped branch target table: valid bits in flops, tag and target
// arrays written without reset so they map onto distributed RAM.
module pf_btb #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_tgt,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_tgt
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [DEPTH-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_mem [DEPTH];
  logic [ADDR_W-1:0] tgt_mem [DEPTH];

  logic [IDX_W-1:0] upd_idx, lk_idx;
  logic [TAG_W-1:0] upd_tag, lk_tag;

  assign upd_idx = upd_pc[IDX_W-1:0];
  assign upd_tag = upd_pc[ADDR_W-1:IDX_W];
  assign lk_idx  = lk_pc[IDX_W-1:0];
  assign lk_tag  = lk_pc[ADDR_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (upd_en) begin
      vld_q[upd_idx] <= upd_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      tag_mem[upd_idx] <= upd_tag;
      tgt_mem[upd_idx] <= upd_tgt;
    end
  end

  // Lookup sees contents before a same-cycle update
  assign lk_hit = vld_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  assign lk_tgt = tgt_mem[lk_idx];
endmodule

// File: rtl/pf_line_buf.sv
// One code line buffer: loads a full line in one beat, then drains bytes
// from a start offset up to an end offset.
module pf_line_buf #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic                          load,
  input  logic [LINE_BYTES*8-1:0]       ld_data,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] ld_line,
  input  logic [$clog2(LINE_BYTES)-1:0] ld_start,
  input  logic [$clog2(LINE_BYTES)-1:0] ld_end,
  input  logic                          ld_taken,
  input  logic                          pop,
  output logic                          full,
  output logic [7:0]                    cur_byte,
  output logic [ADDR_W-1:0]             cur_pc,
  output logic                          last,
  output logic                          taken
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;

  logic [7:0]        bytes_q [LINE_BYTES];
  logic [OFF_W-1:0]  ptr_q, end_q;
  logic [LINE_W-1:0] line_q;
  logic              full_q, taken_q;

  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < LINE_BYTES; i++) begin
        bytes_q[i] <= ld_data[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      full_q  <= 1'b0;
      ptr_q   <= '0;
      end_q   <= '0;
      line_q  <= '0;
      taken_q <= 1'b0;
    end else if (load) begin
      full_q  <= 1'b1;
      ptr_q   <= ld_start;
      end_q   <= ld_end;
      line_q  <= ld_line;
      taken_q <= ld_taken;
    end else if (pop && full_q) begin
      if (ptr_q == end_q) begin
        full_q <= 1'b0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign full     = full_q;
  assign cur_byte = bytes_q[ptr_q];
  assign cur_pc   = {line_q, ptr_q};
  assign last     = (ptr_q == end_q);
  assign taken    = taken_q;
endmodule

// File: rtl/pf_fetch_ctl.sv
// Fetch address generation, active-buffer steering and drain-side select.
module pf_fetch_ctl
  import pf_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              LINE_BYTES = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic [ADDR_W-1:0]             flush_addr,
  output logic                          req_valid,
  input  logic                          req_ready,
  output logic [ADDR_W-1:0]             req_addr,
  input  logic                          rsp_valid,
  input  logic                          rsp_br_valid,
  input  logic [$clog2(LINE_BYTES)-1:0] rsp_br_off,
  output logic [ADDR_W-1:0]             lk_pc,
  input  logic                          lk_hit,
  input  logic [ADDR_W-1:0]             lk_tgt,
  input  logic [1:0]                    buf_full,
  input  logic                          rd_done,
  input  logic                          rd_taken,
  output logic                          load,
  output logic                          act,
  output logic                          rd_sel,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] ld_line,
  output logic [$clog2(LINE_BYTES)-1:0] ld_start,
  output logic [$clog2(LINE_BYTES)-1:0] ld_end,
  output logic                          ld_taken
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

  pf_fetch_state_e   st_q;
  logic [ADDR_W-1:0] fetch_q;
  logic              act_q, rd_q, stale_q;
  logic              br_live, take;

  assign ld_line  = fetch_q[ADDR_W-1:OFF_W];
  assign ld_start = fetch_q[OFF_W-1:0];
  assign lk_pc    = {fetch_q[ADDR_W-1:OFF_W], rsp_br_off};
  assign br_live  = rsp_br_valid && (rsp_br_off >= ld_start);
  assign take     = br_live && lk_hit;
  assign load     = (st_q == FS_WAIT) && rsp_valid && !flush;
  assign ld_end   = take ? rsp_br_off : {OFF_W{1'b1}};
  assign ld_taken = take;

  assign req_valid = (st_q == FS_REQ);
  assign req_addr  = {fetch_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign act       = act_q;
  assign rd_sel    = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= FS_IDLE;
      fetch_q <= RESET_PC;
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      stale_q <= 1'b0;
    end else if (flush) begin
      st_q    <= FS_IDLE;
      fetch_q <= flush_addr;
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      stale_q <= ((st_q == FS_REQ) && req_ready) ||
                 ((st_q == FS_WAIT) && !rsp_valid) ||
                 (stale_q && !rsp_valid);
    end else begin
      if (stale_q && rsp_valid) begin
        stale_q <= 1'b0;
      end
      case (st_q)
        FS_IDLE: begin
          if (!buf_full[act_q] && !stale_q) begin
            st_q <= FS_REQ;
          end
        end
        FS_REQ: begin
          if (req_ready) begin
            st_q <= FS_WAIT;
          end
        end
        FS_WAIT: begin
          if (rsp_valid) begin
            st_q <= FS_IDLE;
            if (take) begin
              fetch_q <= lk_tgt;
              act_q   <= ~act_q;
            end else begin
              fetch_q <= {fetch_q[ADDR_W-1:OFF_W] + LINE_ONE, {OFF_W{1'b0}}};
            end
          end
        end
        default: st_q <= FS_IDLE;
      endcase
      if (rd_done && rd_taken) begin
        rd_q <= ~rd_q;
      end
    end
  end
endmodule

// File: rtl/pf_dual_fetch.sv
// Top: two line buffers, branch table and fetch control.
module pf_dual_fetch #(
  parameter int                ADDR_W     = 32,
  parameter int                LINE_BYTES = 32,
  parameter int                BTB_DEPTH  = 16,
  parameter logic [ADDR_W-1:0] RESET_PC   = '0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic [ADDR_W-1:0]             flush_addr,
  output logic                          req_valid,
  input  logic                          req_ready,
  output logic [ADDR_W-1:0]             req_addr,
  input  logic                          rsp_valid,
  input  logic [LINE_BYTES*8-1:0]       rsp_data,
  input  logic                          rsp_br_valid,
  input  logic [$clog2(LINE_BYTES)-1:0] rsp_br_off,
  input  logic                          upd_en,
  input  logic [ADDR_W-1:0]             upd_pc,
  input  logic [ADDR_W-1:0]             upd_tgt,
  input  logic                          upd_valid,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [7:0]                    out_byte,
  output logic [ADDR_W-1:0]             out_pc
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int NBUF   = 2;

  logic [ADDR_W-1:0] lk_pc, lk_tgt;
  logic              lk_hit;
  logic              load, act, rd_sel, ld_taken;
  logic [LINE_W-1:0] ld_line;
  logic [OFF_W-1:0]  ld_start, ld_end;
  logic              pop_any, rd_done, rd_taken;

  logic [NBUF-1:0]   buf_full, buf_last, buf_taken;
  logic [7:0]        buf_byte [NBUF];
  logic [ADDR_W-1:0] buf_pc   [NBUF];

  pf_btb #(
    .ADDR_W (ADDR_W),
    .DEPTH  (BTB_DEPTH)
  ) u_btb (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (upd_en),
    .upd_pc    (upd_pc),
    .upd_tgt   (upd_tgt),
    .upd_valid (upd_valid),
    .lk_pc     (lk_pc),
    .lk_hit    (lk_hit),
    .lk_tgt    (lk_tgt)
  );

  pf_fetch_ctl #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .RESET_PC   (RESET_PC)
  ) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .flush_addr   (flush_addr),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_br_valid (rsp_br_valid),
    .rsp_br_off   (rsp_br_off),
    .lk_pc        (lk_pc),
    .lk_hit       (lk_hit),
    .lk_tgt       (lk_tgt),
    .buf_full     (buf_full),
    .rd_done      (rd_done),
    .rd_taken     (rd_taken),
    .load         (load),
    .act          (act),
    .rd_sel       (rd_sel),
    .ld_line      (ld_line),
    .ld_start     (ld_start),
    .ld_end       (ld_end),
    .ld_taken     (ld_taken)
  );

  assign out_valid = buf_full[rd_sel];
  assign out_byte  = buf_byte[rd_sel];
  assign out_pc    = buf_pc[rd_sel];
  assign pop_any   = out_valid && out_ready && !flush;
  assign rd_done   = pop_any && buf_last[rd_sel];
  assign rd_taken  = buf_taken[rd_sel];

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    pf_line_buf #(
      .ADDR_W     (ADDR_W),
      .LINE_BYTES (LINE_BYTES)
    ) u_buf (
      .clk      (clk),
      .rst      (rst),
      .clr      (flush),
      .load     (load && (act == 1'(g))),
      .ld_data  (rsp_data),
      .ld_line  (ld_line),
      .ld_start (ld_start),
      .ld_end   (ld_end),
      .ld_taken (ld_taken),
      .pop      (pop_any && (rd_sel == 1'(g))),
      .full     (buf_full[g]),
      .cur_byte (buf_byte[g]),
      .cur_pc   (buf_pc[g]),
      .last     (buf_last[g]),
      .taken    (buf_taken[g])
    );
  end
endmodule

// File: rtl/pf_dual_fetch_chk.sv
module pf_dual_fetch_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_byte,
  input logic [ADDR_W-1:0] out_pc
);
  // R1
  rst_empty_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R3
  req_align_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_addr[OFF_W-1:0] == '0));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !flush) |=> (req_valid && $stable(req_addr)));

  // R4
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_valid);

  // R9
  flush_drop_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=>
      (out_valid && $stable(out_byte) && $stable(out_pc)));
endmodule

bind pf_dual_fetch pf_dual_fetch_chk #(
  .ADDR_W (ADDR_W),
  .OFF_W  ($clog2(LINE_BYTES))
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_byte  (out_byte),
  .out_pc    (out_pc)
);

// File: tb/test_pf_dual_fetch.sv
`timescale 1ns/1ps
module test_pf_dual_fetch;
  localparam int AW = 32;
  localparam int LB = 32;
  localparam int OW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic [AW-1:0] flush_addr = '0;
  logic req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic rsp_valid;
  logic [LB*8-1:0] rsp_data;
  logic rsp_br_valid;
  logic [OW-1:0] rsp_br_off;
  logic upd_en = 1'b0;
  logic [AW-1:0] upd_pc = '0, upd_tgt = '0;
  logic upd_valid = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_byte;
  logic [AW-1:0] out_pc;

  always #10 clk = ~clk;

  pf_dual_fetch #(
    .ADDR_W(AW), .LINE_BYTES(LB), .BTB_DEPTH(16), .RESET_PC(32'h0000_0104)
  ) i_pf_dual_fetch (
    .clk(clk), .rst(rst), .flush(flush), .flush_addr(flush_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_br_valid(rsp_br_valid),
    .rsp_br_off(rsp_br_off), .upd_en(upd_en), .upd_pc(upd_pc), .upd_tgt(upd_tgt),
    .upd_valid(upd_valid), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_pc(out_pc)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Cache model state
  logic [AW-1:0] req_log [64];
  int req_n = 0;
  logic [AW-1:0] pend = '0;
  int lat = 0;
  bit acc = 1'b0;
  logic [AW-1:0] br_line [2];
  logic [OW-1:0] br_off  [2];
  bit            br_on   [2];

  // Captured stream
  logic [AW-1:0] got_pc [256];
  logic [7:0]    got_b  [256];

  function automatic logic [7:0] byte_of(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [LB*8-1:0] mk_line(input logic [AW-1:0] la);
    logic [LB*8-1:0] d;
    for (int i = 0; i < LB; i++) d[8*i +: 8] = byte_of(la + AW'(i));
    return d;
  endfunction

  initial begin
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    rsp_br_valid = 1'b0; rsp_br_off = '0;
    for (int s = 0; s < 2; s++) begin br_on[s] = 1'b0; br_line[s] = '0; br_off[s] = '0; end
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      rsp_br_valid = 1'b0;
      if (acc) begin
        if (req_n < 64) req_log[req_n] = pend;
        req_n++;
        acc = 1'b0;
      end
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          rsp_valid = 1'b1;
          rsp_data = mk_line(pend);
          for (int s = 0; s < 2; s++)
            if (br_on[s] && br_line[s] == pend) begin
              rsp_br_valid = 1'b1; rsp_br_off = br_off[s];
            end
        end
      end
      if (req_ready) begin
        req_ready = 1'b0; acc = 1'b1; lat = 2;
      end else if (req_valid && lat == 0 && !acc && !rst) begin
        req_ready = 1'b1; pend = req_addr;
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    report();
  end

  task automatic check_eq(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic take(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      out_ready = 1'b1;
      if (out_valid) begin
        got_pc[k] = out_pc; got_b[k] = out_byte; k++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic check_run(input string tag, input int from, input int cnt, input logic [AW-1:0] pc0);
    for (int k = 0; k < cnt; k++) begin
      logic [AW-1:0] e;
      e = pc0 + AW'(k);
      check_eq({tag, " pc"}, got_pc[from+k], e);
      check_eq({tag, " byte"}, {24'h0, got_b[from+k]}, {24'h0, byte_of(e)});
    end
  endtask

  task automatic do_flush(input logic [AW-1:0] a);
    flush = 1'b1; flush_addr = a;
    @(negedge clk);
    flush = 1'b0;
    check_eq("R9 out_valid after flush", {31'h0, out_valid}, '0);
    @(negedge clk);
    @(negedge clk);
    req_n = 0;
  endtask

  task automatic btb_write(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input logic v);
    upd_en = 1'b1; upd_pc = pc; upd_tgt = tgt; upd_valid = v;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  task automatic t_reset_seq();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check_eq("R1 out_valid in reset", {31'h0, out_valid}, '0);
    @(negedge clk);
    check_eq("R1 out_valid after reset", {31'h0, out_valid}, '0);
    take(92);
    check_eq("R1 first request", req_log[0], 32'h100);
    check_eq("R2 second request", req_log[1], 32'h120);
    check_eq("R2 third request", req_log[2], 32'h140);
    check_run("R3 start offset", 0, 28, 32'h104);
    check_run("R2 sequential", 28, 64, 32'h120);
  endtask

  task automatic t_backpressure();
    logic [AW-1:0] pc_a;
    logic [7:0] b_a;
    do_flush(32'h200);
    repeat (12) @(negedge clk);
    pc_a = out_pc; b_a = out_byte;
    repeat (18) @(negedge clk);
    check_eq("R4 one line fetched", AW'(req_n), 32'd1);
    check_eq("R4 request address", req_log[0], 32'h200);
    check_eq("R10 out_valid held", {31'h0, out_valid}, 32'd1);
    check_eq("R10 out_pc held", out_pc, pc_a);
    check_eq("R10 out_byte held", {24'h0, out_byte}, {24'h0, b_a});
    check_eq("R10 held pc value", out_pc, 32'h200);
    take(40);
    check_run("R4 resume", 0, 40, 32'h200);
  endtask

  task automatic t_miss();
    br_on[0] = 1'b1; br_line[0] = 32'h300; br_off[0] = 5'd5;
    do_flush(32'h300);
    take(40);
    check_run("R5 branch miss", 0, 40, 32'h300);
    br_on[0] = 1'b0;
  endtask

  task automatic t_hit();
    btb_write(32'h40A, 32'h813, 1'b1);
    br_on[0] = 1'b1; br_line[0] = 32'h400; br_off[0] = 5'd10;
    do_flush(32'h400);
    repeat (30) @(negedge clk);
    check_eq("R6 both buffers filled", AW'(req_n), 32'd2);
    check_eq("R6 target line fetched early", req_log[1], 32'h800);
    check_eq("R6 still draining first", out_pc, 32'h400);
    take(31);
    check_run("R6 up to branch", 0, 11, 32'h400);
    check_run("R6 from target", 11, 20, 32'h813);
    check_eq("R6 sequential after target", req_log[2], 32'h820);
  endtask

  task automatic t_early_branch();
    btb_write(32'h503, 32'h900, 1'b1);
    br_on[0] = 1'b1; br_line[0] = 32'h500; br_off[0] = 5'd3;
    do_flush(32'h508);
    take(30);
    check_run("R7 branch before start ignored", 0, 30, 32'h508);
    br_on[0] = 1'b0;
  endtask

  task automatic t_btb_update();
    br_on[0] = 1'b1; br_line[0] = 32'h400; br_off[0] = 5'd10;
    br_on[1] = 1'b1; br_line[1] = 32'h600; br_off[1] = 5'd26;
    btb_write(32'h40A, 32'h813, 1'b1);
    btb_write(32'h61A, 32'h700, 1'b1);
    do_flush(32'h400);
    take(40);
    check_run("R8 replaced entry misses", 0, 40, 32'h400);
    do_flush(32'h600);
    take(32);
    check_run("R8 new entry hits", 0, 27, 32'h600);
    check_run("R8 new target", 27, 5, 32'h700);
    btb_write(32'h61A, 32'h700, 1'b0);
    do_flush(32'h600);
    take(32);
    check_run("R8 invalidated entry", 0, 32, 32'h600);
    br_on[0] = 1'b0; br_on[1] = 1'b0;
  endtask

  task automatic t_flush_inflight();
    do_flush(32'hA00);
    do_flush(32'hB07);
    take(10);
    check_run("R9 resume at redirect", 0, 10, 32'hB07);
    do_flush(32'hC00);
    take(4);
    flush = 1'b1; flush_addr = 32'hD10;
    @(negedge clk);
    flush = 1'b0;
    check_eq("R9 drop while streaming", {31'h0, out_valid}, '0);
    take(6);
    check_run("R9 second redirect", 0, 6, 32'hD10);
  endtask

  initial begin
    t_reset_seq();
    t_backpressure();
    t_miss();
    t_hit();
    t_early_branch();
    t_btb_update();
    t_flush_inflight();
    report();
  end
endmodule